// File: doc/BRIEF.md
# Multichannel ADC Sampling Sequencer

This block schedules conversions for one 16-bit converter that serves eight analog inputs through an external multiplexer. A programmable divider splits the system clock into sample periods. Each period opens one conversion slot. In that slot the sequencer moves the multiplexer select to the next enabled channel, waits a programmable number of settle cycles, pulses the convert strobe and captures the result when the converter reports done. The result leaves on a valid/ready stream together with a 3-bit channel tag, and a downstream FIFO consumes it.

Software programs four small registers through a write-only port. Address 0 holds the channel enable mask in bits 7:0. Address 1 holds the sample-period divisor. Address 2 holds the settle count in bits 7:0. Address 3 holds the input-mode select in bits 1:0, which steers the converter input to one of four sources: 0 live signal, 1 reference voltage, 2 calibration DAC output, 3 ground.

The output stream has no buffering. `out_valid` is a one-cycle pulse. The consumer takes the word by holding `out_ready` high in that cycle, which is the FIFO's not-full state. If `out_ready` is low in that cycle, the word is lost and the sticky `overrun` flag is set. The producer never stalls or retries.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset, `mux_sel` is 7, `adc_convst`, `out_valid` and `overrun` are 0, `mode_sel` is 0, no channel is enabled, the divisor is 20 and the settle count is 0.
- R2: Slots visit the enabled channels in ascending order and wrap from 7 to 0. Disabled channels are skipped. The first channel after reset is the lowest enabled one. After an enable-mask change, the scan continues upward from the channel last used.
- R3: While the enable mask is zero, `adc_convst` never asserts.
- R4: When every slot completes within its period, consecutive `adc_convst` rises are exactly D cycles apart, where D is the active divisor.
- R5: A divisor write below 20 is ignored. A write of 20 or more takes effect at the next sample boundary, so the period in progress still runs with the old value.
- R6: `adc_convst` rises exactly S+1 cycles after `mux_sel` takes its new value, where S is the settle count in force when the slot started.
- R7: `adc_convst` is high for exactly one cycle, and `mux_sel` does not change between the strobe and the capture.
- R8: `adc_data` sampled in the cycle `adc_done` is high appears on `out_data` in the next cycle, with `out_valid` high for one cycle and `out_chan` equal to the converted channel.
- R9: If `out_ready` is low while `out_valid` is high, that word is dropped and `overrun` becomes 1. It stays 1 until reset.
- R10: A sample boundary that arrives while a slot is still busy starts no slot. With divisor 20 and a slot longer than 20 cycles, strobes are 40 cycles apart.
- R11: `mode_sel` shows the last value written to bits 1:0 of address 3 (0 live, 1 reference, 2 calibration DAC, 3 ground) from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (10 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 divisor, 2 settle, 3 mode |
| reg_wdata | input | 16 | Register write data |
| mux_sel | output | 3 | External multiplexer channel select |
| mode_sel | output | 2 | Converter input source select |
| adc_convst | output | 1 | Convert strobe, one cycle |
| adc_done | input | 1 | Converter result ready |
| adc_data | input | 16 | Converter result |
| out_valid | output | 1 | Tagged sample valid, one-cycle pulse |
| out_ready | input | 1 | Consumer can accept (FIFO not full) |
| out_data | output | 16 | Sample value |
| out_chan | output | 3 | Channel tag of the sample |
| overrun | output | 1 | Sticky flag: a sample was dropped |

## Verification
The assertions check several properties on every cycle: the one-cycle strobe width, a multiplexer select held stable through each conversion, the exact settle distance measured from the start of each slot, the sticky overrun flag and its setting on a refused word, and an active divisor that never drops below 20. Round-robin order over all 255 non-zero enable masks, the period length before and after a divisor write, the ignoring of a too-small divisor, the doubled period when a slot overruns its boundary, and the mode output can only be shown by the bench's scenarios. The bench checks these against channel sequences and gap lengths that it computes itself.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_SETTLE = 2'd1,
    SLOT_WAIT   = 2'd2
  } slot_state_t;

  localparam logic [1:0] ADDR_ENABLE  = 2'd0;
  localparam logic [1:0] ADDR_DIVISOR = 2'd1;
  localparam logic [1:0] ADDR_SETTLE  = 2'd2;
  localparam logic [1:0] ADDR_MODE    = 2'd3;

  localparam int MODE_W = 2;
endpackage

// File: rtl/adc_rate_timebase.sv
module adc_rate_timebase #(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             tick,
  output logic [DIV_W-1:0] div_act
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] div_pend;
  logic [DIV_W-1:0] cnt;

  // The boundary falls on the last count of the active period.
  assign tick = (cnt == div_act - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_pend <= MIN_V;
      div_act  <= MIN_V;
      cnt      <= '0;
    end else begin
      if (div_wr && div_wdata >= MIN_V)
        div_pend <= div_wdata;
      if (tick) begin
        cnt     <= '0;
        div_act <= div_pend;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_chan_picker.sv
module adc_chan_picker #(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic [NCH-1:0]  en,
  input  logic [CH_W-1:0] last,
  output logic [CH_W-1:0] next_ch,
  output logic            any_en
);
  int  idx;
  logic found;

  assign any_en = |en;

  // Scan upward from the channel after the last one, wrapping round once.
  always_comb begin
    next_ch = last;
    found   = 1'b0;
    idx     = 0;
    for (int i = 1; i <= NCH; i++) begin
      idx = (int'(last) + i) % NCH;
      if (!found && en[idx]) begin
        next_ch = CH_W'(idx);
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_slot_ctrl.sv
module adc_slot_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int CH_W     = 3,
  parameter int DATA_W   = 16,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                any_en,
  input  logic [CH_W-1:0]     next_ch,
  input  logic [SETTLE_W-1:0] settle,
  input  logic                adc_done,
  input  logic [DATA_W-1:0]   adc_data,
  input  logic                out_ready,
  output logic [CH_W-1:0]     cur_ch,
  output logic                slot_go,
  output logic                convst,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic [CH_W-1:0]     out_chan,
  output logic                overrun
);
  slot_state_t         state;
  logic [SETTLE_W-1:0] wait_cnt;

  // A boundary only opens a slot when the previous one has finished.
  assign slot_go = tick && any_en && (state == SLOT_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SLOT_IDLE;
      cur_ch    <= CH_W'(NCH - 1);
      wait_cnt  <= '0;
      convst    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
      overrun   <= 1'b0;
    end else begin
      convst    <= 1'b0;
      out_valid <= 1'b0;
      if (out_valid && !out_ready)
        overrun <= 1'b1;
      case (state)
        SLOT_IDLE: begin
          if (slot_go) begin
            cur_ch   <= next_ch;
            wait_cnt <= settle;
            state    <= SLOT_SETTLE;
          end
        end
        SLOT_SETTLE: begin
          if (wait_cnt == '0) begin
            convst <= 1'b1;
            state  <= SLOT_WAIT;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        SLOT_WAIT: begin
          if (adc_done) begin
            out_valid <= 1'b1;
            out_data  <= adc_data;
            out_chan  <= cur_ch;
            state     <= SLOT_IDLE;
          end
        end
        default: state <= SLOT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
  import adc_seq_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int DATA_W   = 16,
  parameter int DIV_W    = 16,
  parameter int MIN_DIV  = 20,
  parameter int SETTLE_W = 8,
  parameter int CH_W     = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DIV_W-1:0]  reg_wdata,
  output logic [CH_W-1:0]   mux_sel,
  output logic [MODE_W-1:0] mode_sel,
  output logic              adc_convst,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CH_W-1:0]   out_chan,
  output logic              overrun
);
  logic [NCH-1:0]      en_q;
  logic [SETTLE_W-1:0] settle_q;
  logic [MODE_W-1:0]   mode_q;
  logic                tick;
  logic [DIV_W-1:0]    div_act;
  logic [CH_W-1:0]     next_ch;
  logic                any_en;
  logic                slot_go;
  logic                div_wr;

  assign div_wr = reg_wr && (reg_addr == ADDR_DIVISOR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      settle_q <= '0;
      mode_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_ENABLE: en_q     <= reg_wdata[NCH-1:0];
        ADDR_SETTLE: settle_q <= reg_wdata[SETTLE_W-1:0];
        ADDR_MODE:   mode_q   <= reg_wdata[MODE_W-1:0];
        default: ;
      endcase
    end
  end

  assign mode_sel = mode_q;

  adc_rate_timebase #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_wr    (div_wr),
    .div_wdata (reg_wdata),
    .tick      (tick),
    .div_act   (div_act)
  );

  adc_chan_picker #(.NCH(NCH), .CH_W(CH_W)) u_picker (
    .en      (en_q),
    .last    (mux_sel),
    .next_ch (next_ch),
    .any_en  (any_en)
  );

  adc_slot_ctrl #(
    .NCH(NCH), .CH_W(CH_W), .DATA_W(DATA_W), .SETTLE_W(SETTLE_W)
  ) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .any_en    (any_en),
    .next_ch   (next_ch),
    .settle    (settle_q),
    .adc_done  (adc_done),
    .adc_data  (adc_data),
    .out_ready (out_ready),
    .cur_ch    (mux_sel),
    .slot_go   (slot_go),
    .convst    (adc_convst),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_chan  (out_chan),
    .overrun   (overrun)
  );
endmodule

// File: rtl/adc_scan_checker.sv
module adc_scan_checker #(
  parameter int CH_W     = 3,
  parameter int DIV_W    = 16,
  parameter int MIN_DIV  = 20,
  parameter int SETTLE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                adc_convst,
  input logic [CH_W-1:0]     mux_sel,
  input logic                out_valid,
  input logic                out_ready,
  input logic                overrun,
  input logic                slot_go,
  input logic [SETTLE_W-1:0] settle_q,
  input logic [DIV_W-1:0]    div_act
);
  logic [SETTLE_W:0]   since_go;
  logic [SETTLE_W-1:0] settle_at_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_go     <= '0;
      settle_at_go <= '0;
    end else if (slot_go) begin
      since_go     <= '0;
      settle_at_go <= settle_q;
    end else if (since_go != {(SETTLE_W+1){1'b1}}) begin
      since_go <= since_go + 1'b1;
    end
  end

  // R6: strobe lands exactly settle+1 cycles after the slot started
  p_settle_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_convst) |-> (since_go == ({1'b0, settle_at_go} + 1'b1)));

  // R7: strobe lasts one cycle
  p_strobe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adc_convst |=> !adc_convst);

  // R7: select is steady while a conversion is under way
  p_mux_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adc_convst |=> $stable(mux_sel));

  // R9: a refused word raises overrun
  p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> overrun);

  // R9: overrun never clears outside reset
  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R5: the active divisor never falls below the minimum
  p_div_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_act >= DIV_W'(MIN_DIV));
endmodule

bind adc_scan_sequencer adc_scan_checker #(
  .CH_W(CH_W), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV), .SETTLE_W(SETTLE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adc_convst (adc_convst),
  .mux_sel    (mux_sel),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .overrun    (overrun),
  .slot_go    (slot_go),
  .settle_q   (settle_q),
  .div_act    (div_act)
);

// File: tb/adc_scan_sequencer_test.sv
module adc_scan_sequencer_test;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [2:0]  mux_sel;
  logic [1:0]  mode_sel;
  logic        adc_convst;
  logic        adc_done = 1'b0;
  logic [15:0] adc_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic [2:0]  out_chan;
  logic        overrun;

  adc_scan_sequencer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mux_sel(mux_sel), .mode_sel(mode_sel),
    .adc_convst(adc_convst), .adc_done(adc_done), .adc_data(adc_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chan(out_chan), .overrun(overrun)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] next_en(input logic [2:0] last, input logic [7:0] m);
    logic [2:0] r = last;
    bit hit = 0;
    for (int i = 1; i <= 8; i++) begin
      int k = (int'(last) + i) % 8;
      if (!hit && m[k]) begin r = 3'(k); hit = 1; end
    end
    return r;
  endfunction

  // Monitor and converter model, both at the falling edge
  int         cyc = 0;
  int         n_rises = 0, n_push = 0;
  int         last_rise = -1, last_gap = 0;
  int         mux_t = 0, settle_gap = 0;
  int         lat_cnt = 0;
  logic [2:0] prev_mux = 3'd7;
  logic [2:0] conv_ch = '0;
  logic [2:0] model_last = 3'd7;
  logic [7:0] model_mask = '0;
  logic [15:0] sent = '0;
  logic       prev_conv = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mux_sel != prev_mux) mux_t = cyc;
      prev_mux = mux_sel;
      if (out_valid) begin
        logic [2:0] e;
        e = next_en(model_last, model_mask);
        check(out_chan == e, "R2 channel order", out_chan, e);
        check(out_data == sent, "R8 captured data", out_data, sent);
        model_last = e;
        n_push++;
      end
      adc_done = 1'b0;
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          check(mux_sel == conv_ch, "R7 mux steady", mux_sel, conv_ch);
          sent = 16'h5A00 ^ {5'd0, conv_ch, 8'd0} ^ 16'(cyc);
          adc_data = sent;
          adc_done = 1'b1;
        end
      end
      if (adc_convst) begin
        check(!prev_conv, "R7 strobe width", int'(prev_conv), 0);
        if (!prev_conv) begin
          if (last_rise >= 0) last_gap = cyc - last_rise;
          last_rise = cyc;
          settle_gap = cyc - mux_t;
          n_rises++;
          conv_ch = mux_sel;
          lat_cnt = LAT;
        end
      end
      prev_conv = adc_convst;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_push(input int n);
    int t;
    t = n_push + n;
    wait (n_push >= t);
  endtask

  task automatic wait_rise(input int n);
    int t;
    t = n_rises + n;
    wait (n_rises >= t);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(mux_sel == 3'd7, "R1 mux_sel", mux_sel, 7);
    check(adc_convst == 1'b0, "R1 convst", adc_convst, 0);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(overrun == 1'b0, "R1 overrun", overrun, 0);
    check(mode_sel == 2'd0, "R1 mode_sel", mode_sel, 0);

    // R3: nothing enabled, no strobes
    repeat (100) @(negedge clk);
    check(n_rises == 0, "R3 idle", n_rises, 0);

    // R2/R8: sweep of every non-zero mask
    wr(2'd2, 16'd2);
    for (int m = 1; m < 256; m++) begin
      model_mask = 8'(m);
      wr(2'd0, 16'(m));
      wait_push($countones(8'(m)) + 1);
    end

    // R4: full scan with divisor 20
    model_mask = 8'hFF;
    wr(2'd0, 16'h00FF);
    wait_rise(3);
    check(last_gap == 20, "R4 period", last_gap, 20);

    // R5: new divisor waits for the boundary
    wait_push(1);
    wr(2'd1, 16'd30);
    wait_rise(1);
    check(last_gap == 20, "R5 old period kept", last_gap, 20);
    wait_rise(1);
    check(last_gap == 30, "R5 new period", last_gap, 30);
    wait_push(1);
    wr(2'd1, 16'd19);
    wr(2'd1, 16'd5);
    wait_rise(2);
    check(last_gap == 30, "R5 small divisor ignored", last_gap, 30);
    wait_push(1);
    wr(2'd1, 16'd20);
    wait_rise(2);
    check(last_gap == 20, "R4 period restored", last_gap, 20);

    // R6: settle distance with two alternating channels
    wait_push(1);
    model_mask = 8'h05;
    wr(2'd0, 16'h0005);
    wr(2'd2, 16'd4);
    wait_rise(2);
    check(settle_gap == 5, "R6 settle", settle_gap, 5);
    wait_rise(1);
    check(settle_gap == 5, "R6 settle again", settle_gap, 5);

    // R10: slot longer than the period skips a boundary
    wait_push(1);
    wr(2'd2, 16'd25);
    wait_rise(3);
    check(last_gap == 40, "R10 skipped boundary", last_gap, 40);
    wait_push(1);
    wr(2'd2, 16'd2);
    wait_push(2);

    // R9: refused word sets sticky overrun
    check(overrun == 1'b0, "R9 clear before", overrun, 0);
    out_ready = 1'b0;
    wait_push(1);
    @(negedge clk);
    out_ready = 1'b1;
    check(overrun == 1'b1, "R9 overrun set", overrun, 1);
    wait_push(2);
    @(negedge clk);
    check(overrun == 1'b1, "R9 overrun sticky", overrun, 1);

    // R11: input-mode select
    for (int k = 0; k < 4; k++) begin
      wr(2'd3, 16'hFFFC | 16'(k));
      check(mode_sel == 2'(k), "R11 mode", mode_sel, k);
    end

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule